// File: doc/BRIEF.md
# FIFO Destination Tag Unpacker

This block is the receiving end of a word-stream channel. A first-word-fall-through FIFO ahead of it carries a mix of headers and payload. Each header is four 32-bit words. From it the block takes a destination byte address, a payload word count and a "last block" indication. It then copies that many payload words from the FIFO into a word-wide memory write port, with the address rising by four bytes per word.

Software arms the block with a one-cycle `start` pulse. Once armed, the block keeps fetching headers and copying payload until it has finished a block whose header marks it as the last one. It then drops `busy` and gives a single-cycle completion pulse, which the interrupt logic of the channel uses to clear its running flag.

Headers are taken only when the FIFO already holds all four header words. Payload words leave the FIFO only in a cycle where the memory accepts them.

Top module: `fifo_tag_unpacker`

## Requirements
- R1: After reset `busy`, `doneIrq`, `fifoPop` and `memWrEn` are all low.
- R2: While `busy` is low the FIFO is left untouched, whatever its fill level: `fifoPop` and `memWrEn` stay low. Only a `start` pulse sets `busy`, one cycle later.
- R3: A header is fetched only when the remaining payload count is zero, the last-block flag is clear and `fifoLevel` is at least 4. The four header words are then popped in four consecutive cycles with no memory write. With fewer than 4 words present, nothing is popped.
- R4: The destination byte address is bits 23:0 of header word 0. Bits 31:24 of word 0 and all of header words 2 and 3 have no effect on the writes.
- R5: The payload count is bits 23:0 of header word 1, and exactly that many memory writes follow the header.
- R6: A header is a last block when bit 31 of word 1 (the interrupt flag) is set, or bit 30 of word 1 is set (bit 2 of the 3-bit ID field in bits 30:28). Any other header is not a last block.
- R7: Payload word k of a block (counting from 0) is written with `memData` equal to that FIFO word and `memAddr` equal to the header address plus 4·k, modulo 2^24.
- R8: A payload word is popped only in the cycle it is written (`memWrEn` and `memReady` both high). While `memReady` is low, `memWrEn` stays up, `memAddr` holds and nothing is popped.
- R9: When the payload of a last block is complete (or it had none), `busy` falls and `doneIrq` is high for exactly one cycle, in the first cycle with `busy` low.
- R10: After a block that is not last (including one with a zero count), the block stays busy, gives no completion pulse and waits for the next header.
- R11: A `start` pulse while `busy` is high has no effect: after the completion the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle arm pulse |
| fifoData | input | 32 | Head word of the FIFO (fall-through) |
| fifoLevel | input | 8 | Number of words held in the FIFO |
| fifoPop | output | 1 | Remove the head word at this edge |
| memWrEn | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts the write this cycle |
| memAddr | output | 24 | Byte address of the write |
| memData | output | 32 | Write data |
| busy | output | 1 | Channel armed and working |
| doneIrq | output | 1 | One-cycle completion pulse |

## Verification
The bench targets four corner cases:
- A FIFO holding three of the four header words. A design that fetched early would pop a partial header and then read payload as header fields.
- Headers whose last-block status comes from only one of the two bits. A design decoding the wrong bit would either hang waiting for a further header or stop early and leave payload in the FIFO.
- Zero-count headers and addresses near the top of the 24-bit space. These expose a count that underflows into a huge transfer, or an address that carries into the discarded upper byte.
- Random memory back-pressure. A design that popped without an accepted write would lose words, and the per-word address and data comparison would show it.

// File: rtl/tag_unpack_pkg.sv
package tag_unpack_pkg;
  localparam int TAG_WORDS    = 4;
  localparam int IRQ_BIT      = 31;
  localparam int ID_LSB       = 28;
  localparam int ID_FINAL_BIT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_TAG,
    ST_COPY,
    ST_FIN
  } unpackState_e;

  typedef struct packed {
    logic loadAddr;
    logic loadCtl;
    logic advance;
    logic clearAll;
  } dpStrobe_t;
endpackage

// File: rtl/tag_unpack_ctrl.sv
module tag_unpack_ctrl
  import tag_unpack_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             memReady,
  input  logic             countZero,
  input  logic             countOne,
  input  logic             finalFlag,
  output dpStrobe_t        strobe,
  output logic             fifoPop,
  output logic             memWrEn,
  output logic             busy,
  output logic             doneIrq
);
  localparam int IDX_W = $clog2(TAG_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TAG_WORDS - 1);
  localparam logic [LVL_W-1:0] TAG_LVL  = LVL_W'(TAG_WORDS);

  unpackState_e state, nextState;
  logic [IDX_W-1:0] tagIdx;

  always_comb begin
    nextState = state;
    strobe    = '0;
    fifoPop   = 1'b0;
    memWrEn   = 1'b0;
    case (state)
      ST_IDLE: if (start) nextState = ST_EVAL;
      ST_EVAL: begin
        if (finalFlag)                nextState = ST_FIN;
        else if (fifoLevel >= TAG_LVL) nextState = ST_TAG;
      end
      ST_TAG: begin
        fifoPop         = 1'b1;
        strobe.loadAddr = (tagIdx == '0);
        strobe.loadCtl  = (tagIdx == IDX_W'(1));
        if (tagIdx == LAST_IDX) nextState = countZero ? ST_EVAL : ST_COPY;
      end
      ST_COPY: begin
        memWrEn = (fifoLevel != '0);
        if (memWrEn && memReady) begin
          fifoPop        = 1'b1;
          strobe.advance = 1'b1;
          if (countOne) nextState = ST_EVAL;
        end
      end
      ST_FIN: begin
        strobe.clearAll = 1'b1;
        nextState       = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tagIdx  <= '0;
      doneIrq <= 1'b0;
    end else begin
      state   <= nextState;
      tagIdx  <= (state == ST_TAG) ? tagIdx + IDX_W'(1) : '0;
      doneIrq <= (state == ST_FIN);
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/tag_unpack_dp.sv
module tag_unpack_dp
  import tag_unpack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] fifoData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              countZero,
  output logic              countOne,
  output logic              finalFlag
);
  localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(4);

  logic [CNT_W-1:0] wordsLeft;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      memAddr   <= '0;
      wordsLeft <= '0;
      finalFlag <= 1'b0;
    end else begin
      if (strobe.loadAddr) memAddr <= fifoData[ADDR_W-1:0];
      if (strobe.loadCtl) begin
        wordsLeft <= fifoData[CNT_W-1:0];
        finalFlag <= fifoData[IRQ_BIT] | fifoData[ID_LSB + ID_FINAL_BIT];
      end
      if (strobe.advance) begin
        memAddr   <= memAddr + BYTE_STEP;
        wordsLeft <= wordsLeft - CNT_W'(1);
      end
    end
  end

  assign countZero = (wordsLeft == '0);
  assign countOne  = (wordsLeft == CNT_W'(1));
endmodule

// File: rtl/fifo_tag_unpacker.sv
module fifo_tag_unpacker
  import tag_unpack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 24,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] fifoData,
  input  logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoPop,
  output logic              memWrEn,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              busy,
  output logic              doneIrq
);
  dpStrobe_t strobe;
  logic countZero, countOne, finalFlag;

  tag_unpack_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .fifoLevel(fifoLevel),
    .memReady(memReady), .countZero(countZero), .countOne(countOne),
    .finalFlag(finalFlag), .strobe(strobe), .fifoPop(fifoPop),
    .memWrEn(memWrEn), .busy(busy), .doneIrq(doneIrq)
  );

  tag_unpack_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fifoData(fifoData),
    .memAddr(memAddr), .countZero(countZero), .countOne(countOne),
    .finalFlag(finalFlag)
  );

  assign memData = fifoData;
endmodule

// File: rtl/tag_unpack_checker.sv
module tag_unpack_checker #(
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic              fifoPop,
  input logic              memWrEn,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              doneIrq
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!fifoPop && !memWrEn));

  assert_no_pop_stalled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memReady) |-> !fifoPop);

  assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memReady) |=> $stable(memAddr));

  assert_write_has_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (fifoLevel != '0));

  assert_pop_has_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (fifoLevel != '0));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  assert_irq_on_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!busy && $past(busy)));
endmodule

bind fifo_tag_unpacker tag_unpack_checker #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel), .fifoPop(fifoPop),
  .memWrEn(memWrEn), .memReady(memReady), .memAddr(memAddr),
  .busy(busy), .doneIrq(doneIrq)
);

// File: tb/tb_fifo_tag_unpacker.sv
`timescale 1ns/1ps
module tb_fifo_tag_unpacker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] fifoData = '0;
  logic [7:0] fifoLevel = '0;
  logic fifoPop, memWrEn;
  logic memReady = 1'b1;
  logic [23:0] memAddr;
  logic [31:0] memData;
  logic busy, doneIrq;

  always #2 clk = ~clk;

  fifo_tag_unpacker dut (
    .clk(clk), .rstN(rstN), .start(start), .fifoData(fifoData),
    .fifoLevel(fifoLevel), .fifoPop(fifoPop), .memWrEn(memWrEn),
    .memReady(memReady), .memAddr(memAddr), .memData(memData),
    .busy(busy), .doneIrq(doneIrq)
  );

  logic [31:0] fifoQ[$];
  logic [55:0] expQ[$];
  int checks = 0, errors = 0, pops = 0, irqs = 0;
  bit popPend = 0, stallMode = 0, startReq = 0, stallSeen = 0;
  logic [23:0] stallAddr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    logic [31:0] tmp;
    logic [55:0] e;
    @(negedge clk);
    if (popPend && fifoQ.size() != 0) tmp = fifoQ.pop_front();
    popPend   = 0;
    fifoData  = (fifoQ.size() != 0) ? fifoQ[0] : 32'h0;
    fifoLevel = (fifoQ.size() > 255) ? 8'hFF : 8'(fifoQ.size());
    memReady  = stallMode ? ($urandom_range(0, 3) != 0) : 1'b1;
    start     = startReq;
    startReq  = 0;
    #1;
    if (stallSeen && memWrEn) chk(memAddr == stallAddr, "R8", "addr held in stall", memAddr, stallAddr);
    stallSeen = memWrEn && !memReady;
    stallAddr = memAddr;
    if (memWrEn && !memReady) chk(!fifoPop, "R8", "pop while stalled", fifoPop, 0);
    if (fifoPop) begin pops++; popPend = 1; end
    if (memWrEn && memReady) begin
      if (expQ.size() == 0) chk(0, "R5", "unexpected write", memAddr, 0);
      else begin
        e = expQ.pop_front();
        chk(memAddr == e[55:32], "R7", "write addr", memAddr, e[55:32]);
        chk(memData == e[31:0],  "R7", "write data", memData, e[31:0]);
      end
    end
    if (doneIrq) irqs++;
  endtask

  task automatic runN(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  // mode 0: not last, 1: last via flag bit 31, 2: last via ID bit 2 (bit 30)
  function automatic logic [31:0] mkW1(input int n, input int mode);
    logic [2:0] id;
    id = 3'($urandom_range(0, 3));
    if (mode == 2) id[2] = 1'b1;
    return {(mode == 1), id, 4'($urandom), 24'(n)};
  endfunction

  task automatic pushTag(input logic [23:0] a, input int n, input int mode);
    fifoQ.push_back({8'($urandom), a});
    fifoQ.push_back(mkW1(n, mode));
    fifoQ.push_back($urandom);
    fifoQ.push_back($urandom);
    for (int k = 0; k < n; k++) begin
      logic [31:0] d;
      d = $urandom;
      fifoQ.push_back(d);
      expQ.push_back({a + 24'(4 * k), d});
    end
  endtask

  task automatic runUntilIrq(input int limit, input string req);
    int i0, n;
    i0 = irqs; n = 0;
    while (irqs == i0 && n < limit) begin cycle(); n++; end
    chk(irqs == i0 + 1, req, "completion pulse seen", irqs - i0, 1);
    chk(!busy, "R9", "busy low at pulse", busy, 0);
    cycle();
    chk(!doneIrq, "R9", "pulse one cycle", doneIrq, 0);
    chk(expQ.size() == 0, "R5", "all payload written", expQ.size(), 0);
    chk(fifoQ.size() == 0, "R3", "fifo drained", fifoQ.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    runN(4);
    rstN = 1'b1;
    runN(1);
    // R1 reset state
    chk(!busy, "R1", "busy", busy, 0);
    chk(!doneIrq, "R1", "doneIrq", doneIrq, 0);
    chk(!fifoPop, "R1", "fifoPop", fifoPop, 0);
    chk(!memWrEn, "R1", "memWrEn", memWrEn, 0);

    // R2 idle ignores FIFO; R6 last via bit 31; R4 upper byte ignored
    pushTag(24'h001000, 2, 1);
    runN(10);
    chk(pops == 0, "R2", "no pop while idle", pops, 0);
    chk(fifoQ.size() == 6, "R2", "fifo untouched", fifoQ.size(), 6);
    chk(!busy, "R2", "still idle", busy, 0);
    startReq = 1;
    cycle();
    cycle();
    chk(busy, "R2", "busy after start", busy, 1);
    runUntilIrq(100, "R6");

    // R6 last via ID bit 2, R4 address near top wraps within 24 bits
    pushTag(24'hFFFFF8, 4, 2);
    startReq = 1;
    runUntilIrq(100, "R4");

    // R10 non-last block then wait; R3 partial header not taken
    pushTag(24'h000200, 3, 0);
    startReq = 1;
    runN(40);
    chk(busy, "R10", "busy after non-last block", busy, 1);
    chk(irqs == 2, "R10", "no completion yet", irqs, 2);
    fifoQ.push_back({8'hAB, 24'h000300});
    fifoQ.push_back(mkW1(0, 1));
    fifoQ.push_back($urandom);
    pops = 0;
    runN(20);
    chk(pops == 0, "R3", "no pop with 3 words", pops, 0);
    chk(fifoQ.size() == 3, "R3", "partial header kept", fifoQ.size(), 3);
    fifoQ.push_back($urandom);
    runUntilIrq(100, "R3");

    // R10 zero-count non-last then last; R11 start while busy
    stallMode = 1;
    pushTag(24'h000400, 0, 0);
    pushTag(24'h000500, 5, 2);
    startReq = 1;
    runN(4);
    startReq = 1;
    runUntilIrq(200, "R10");
    runN(6);
    chk(!busy, "R11", "start while busy ignored", busy, 0);

    // random chains
    for (int t = 0; t < 30; t++) begin
      int nTags;
      stallMode = ($urandom_range(0, 1) == 1);
      nTags = $urandom_range(1, 3);
      for (int j = 0; j < nTags; j++)
        pushTag(24'($urandom), $urandom_range(0, 12),
                (j == nTags - 1) ? $urandom_range(1, 2) : 0);
      startReq = 1;
      runUntilIrq(2000, "R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule